// File: doc/BRIEF.md
# Byte-Serial Master Port with Bus-Contention Detection

This block is the master side of a four-wire synchronous serial link. After a data write it exchanges one byte with a slave. The byte goes out most significant bit first on the serial output while the serial input is sampled on the opposite edges. The serial clock is a fixed divide of the system clock, and a two-bit rate field chooses the divide. A clock-polarity bit and a clock-phase bit select one of four timing modes, and the slave must use the same mode.

Software sees the block through strobes. A configuration write loads enable, master, polarity, phase and rate. A data write starts a transfer. A data read and a status read are used to acknowledge flags. The received byte and three flags (transfer done, write collision, mode fault) are outputs.

While the block is the enabled master it watches its own select input. A low level there means another master has claimed the bus. The block then drops its enable and master bits, stops any transfer in progress, parks the clock at its idle level and raises the mode-fault flag. This check is masked while the select pin is configured as a general output.

Top module: `spi_mf_master`

## Requirements
- R1: A transfer shifts exactly 8 bits. The transmitted byte appears on `mosi` MSB first, the `miso` bits are assembled MSB first into `rx_data`, and `sck` makes exactly 16 edges.
- R2: When idle, `sck` rests at the polarity bit. With phase 0 the slave-side data are sampled on the first, third and later odd-numbered edges; with phase 1 they are sampled on the second, fourth and later even-numbered edges.
- R3: Each `mosi` bit is already valid during the system-clock cycle before the `sck` edge on which it is sampled, which is half a serial-clock period earlier.
- R4: Rate codes 0, 1, 2 and 3 give an `sck` period of 2, 4, 16 and 32 system clocks. Each half period is therefore 1, 2, 8 or 16 clocks, and the first edge comes one half period after the start.
- R5: `flag_done` is set on the cycle `busy` falls after the eighth bit. It is cleared only by a `sts_rd` pulse while the flag is set, followed by a later data access (`dat_rd` or `dat_wr`). A data access with no status read before it leaves the flag set.
- R6: A `dat_wr` while `busy` is high sets `flag_wcol` and leaves the byte being shifted unchanged. The flag is cleared by a status read followed by a data access.
- R7: While enabled as master with `ss_dir` = 0, a low `ss_n` (after a two-stage synchronizer) sets `flag_mfault`, clears `en_o` and `mstr_o`, aborts any transfer without setting `flag_done`, and returns `sck` to the polarity bit. The flag is cleared by a status read followed by a configuration write.
- R8: With `ss_dir` = 1, `ss_n` has no effect. No fault is raised and transfers complete normally.
- R9: A `dat_wr` starts a transfer only when enable and master are both set. Otherwise it is ignored: `busy` stays low and `sck` does not move.
- R10: After reset, `sck`, `mosi`, `busy`, `rx_data`, every flag, `en_o` and `mstr_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe (ignored while busy) |
| cfg_en | input | 1 | Enable bit to load |
| cfg_mstr | input | 1 | Master bit to load |
| cfg_cpol | input | 1 | Clock polarity to load |
| cfg_cpha | input | 1 | Clock phase to load |
| cfg_rate | input | 2 | Rate code to load |
| dat_wr | input | 1 | Data write strobe; starts a transfer |
| dat_wdata | input | 8 | Byte to transmit |
| dat_rd | input | 1 | Data read strobe (flag acknowledge) |
| sts_rd | input | 1 | Status read strobe (arms flag clearing) |
| ss_dir | input | 1 | 1 = select pin used as general output; masks fault detection |
| ss_n | input | 1 | Own select input, active low |
| miso | input | 1 | Serial data from slave |
| rx_data | output | 8 | Last received byte |
| busy | output | 1 | Transfer in progress |
| flag_done | output | 1 | Transfer-complete flag |
| flag_wcol | output | 1 | Write-collision flag |
| flag_mfault | output | 1 | Mode-fault flag |
| en_o | output | 1 | Current enable bit |
| mstr_o | output | 1 | Current master bit |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |

## Verification
The bench uses the defaults: an 8-bit data width and a two-stage select synchronizer. With these values every polarity/phase pair can be crossed with every rate code, using several byte patterns per combination, and a whole transfer lasts at most about 260 clocks. That lets the bench measure every half period and count every one of the 16 edges. The short synchronizer puts the fault reaction within a few cycles, so an abort in the middle of a transfer and the masked case can both be checked directly at the pins.

// File: rtl/spi_mf_pkg.sv
package spi_mf_pkg;

  localparam int DIV_W = 5;

  typedef struct packed {
    logic       en;
    logic       mstr;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } spi_cfg_t;

  // Half serial-clock period in system clocks for a rate code.
  function automatic logic [DIV_W-1:0] half_len(input logic [1:0] rate);
    logic [DIV_W-1:0] v;
    case (rate)
      2'd0:    v = DIV_W'(1);
      2'd1:    v = DIV_W'(2);
      2'd2:    v = DIV_W'(8);
      default: v = DIV_W'(16);
    endcase
    return v;
  endfunction

endpackage

// File: rtl/spi_mf_clkgen.sv
module spi_mf_clkgen
  import spi_mf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] half;

  always_comb begin
    half  = half_len(rate);
    tick  = run && (cnt_q == half - DIV_W'(1));
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/spi_mf_shifter.sv
module spi_mf_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              sample_en,
  input  logic              shift_en,
  input  logic              finish,
  input  logic              cpha,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_data
);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic              smp_q, smp_d;

  always_comb begin
    sh_d  = sh_q;
    rx_d  = rx_q;
    smp_d = smp_q;
    if (sample_en) smp_d = miso;
    if (load)
      sh_d = load_data;
    else if (shift_en)
      sh_d = {sh_q[DATA_W-2:0], smp_q};
    if (finish)
      rx_d = {sh_q[DATA_W-2:0], (cpha ? miso : smp_q)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      rx_q  <= '0;
      smp_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      rx_q  <= rx_d;
      smp_q <= smp_d;
    end
  end

  assign mosi    = sh_q[DATA_W-1];
  assign rx_data = rx_q;

endmodule

// File: rtl/spi_mf_flags.sv
module spi_mf_flags #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  input  logic          sts_rd,
  output logic [NF-1:0] flag_o
);

  for (genvar i = 0; i < NF; i++) begin : g_flag
    logic f_q, f_d, a_q, a_d;

    always_comb begin
      f_d = f_q;
      a_d = a_q;
      if (sts_rd && f_q) a_d = 1'b1;
      if (a_q && clr_i[i]) begin
        f_d = 1'b0;
        a_d = 1'b0;
      end
      if (set_i[i]) f_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        f_q <= 1'b0;
        a_q <= 1'b0;
      end else begin
        f_q <= f_d;
        a_q <= a_d;
      end
    end

    assign flag_o[i] = f_q;
  end

endmodule

// File: rtl/spi_mf_master.sv
module spi_mf_master
  import spi_mf_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_en,
  input  logic              cfg_mstr,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [1:0]        cfg_rate,
  input  logic              dat_wr,
  input  logic [DATA_W-1:0] dat_wdata,
  input  logic              dat_rd,
  input  logic              sts_rd,
  input  logic              ss_dir,
  input  logic              ss_n,
  input  logic              miso,
  output logic [DATA_W-1:0] rx_data,
  output logic              busy,
  output logic              flag_done,
  output logic              flag_wcol,
  output logic              flag_mfault,
  output logic              en_o,
  output logic              mstr_o,
  output logic              sck,
  output logic              mosi
);

  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES);

  spi_cfg_t                cfg_q, cfg_d;
  logic                    busy_q, busy_d;
  logic [EW-1:0]           edg_q, edg_d;
  logic                    sck_q, sck_d;
  logic [SYNC_STAGES-1:0]  ss_sync;
  logic                    tick, fault, start, collide, last;
  logic                    sample_en, shift_en, finish;
  logic [2:0]              flags;

  // select-input synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ss_sync <= '1;
    else        ss_sync <= {ss_sync[SYNC_STAGES-2:0], ss_n};
  end

  assign fault   = cfg_q.en && cfg_q.mstr && !ss_dir && !ss_sync[SYNC_STAGES-1];
  assign start   = dat_wr && !busy_q && cfg_q.en && cfg_q.mstr && !fault;
  assign collide = dat_wr && busy_q;
  assign last    = busy_q && tick && (edg_q == EW'(EDGES - 1));

  always_comb begin
    sample_en = busy_q && tick && (cfg_q.cpha ? edg_q[0] : !edg_q[0]);
    shift_en  = busy_q && tick && !last &&
                (cfg_q.cpha ? (!edg_q[0] && (edg_q != '0)) : edg_q[0]);
    finish    = last && !fault;
  end

  spi_mf_clkgen u_clkgen (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy_q),
    .rate  (cfg_q.rate),
    .tick  (tick)
  );

  always_comb begin
    cfg_d  = cfg_q;
    busy_d = busy_q;
    edg_d  = edg_q;
    sck_d  = sck_q;
    if (cfg_wr && !busy_q) begin
      cfg_d.en   = cfg_en;
      cfg_d.mstr = cfg_mstr;
      cfg_d.cpol = cfg_cpol;
      cfg_d.cpha = cfg_cpha;
      cfg_d.rate = cfg_rate;
    end
    if (start) begin
      busy_d = 1'b1;
      edg_d  = '0;
    end else if (busy_q && tick) begin
      sck_d = ~sck_q;
      edg_d = edg_q + EW'(1);
      if (last) busy_d = 1'b0;
    end
    if (!busy_q) sck_d = cfg_d.cpol;
    if (fault) begin
      cfg_d.en   = 1'b0;
      cfg_d.mstr = 1'b0;
      busy_d     = 1'b0;
      edg_d      = '0;
      sck_d      = cfg_d.cpol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      busy_q <= 1'b0;
      edg_q  <= '0;
      sck_q  <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      busy_q <= busy_d;
      edg_q  <= edg_d;
      sck_q  <= sck_d;
    end
  end

  spi_mf_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .load_data (dat_wdata),
    .sample_en (sample_en),
    .shift_en  (shift_en),
    .finish    (finish),
    .cpha      (cfg_q.cpha),
    .miso      (miso),
    .mosi      (mosi),
    .rx_data   (rx_data)
  );

  spi_mf_flags #(.NF(3)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  ({fault, collide, finish}),
    .clr_i  ({cfg_wr, (dat_wr || dat_rd), (dat_wr || dat_rd)}),
    .sts_rd (sts_rd),
    .flag_o (flags)
  );

  assign flag_done   = flags[0];
  assign flag_wcol   = flags[1];
  assign flag_mfault = flags[2];
  assign busy        = busy_q;
  assign sck         = sck_q;
  assign en_o        = cfg_q.en;
  assign mstr_o      = cfg_q.mstr;

endmodule

// File: rtl/spi_mf_master_chk.sv
module spi_mf_master_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic sck,
  input logic cpol,
  input logic en,
  input logic mstr,
  input logic dat_wr,
  input logic ss_dir,
  input logic flag_done,
  input logic flag_wcol,
  input logic flag_mfault
);

  assert_idle_sck_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == cpol));

  assert_start_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(en && mstr));

  assert_collision_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && busy) |=> flag_wcol);

  assert_fault_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_mfault) |-> (!en && !mstr && !busy));

  assert_fault_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_mfault) |-> $past(!ss_dir));

  assert_done_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_done) |-> $fell(busy));

endmodule

bind spi_mf_master spi_mf_master_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy_q),
  .sck         (sck_q),
  .cpol        (cfg_q.cpol),
  .en          (cfg_q.en),
  .mstr        (cfg_q.mstr),
  .dat_wr      (dat_wr),
  .ss_dir      (ss_dir),
  .flag_done   (flag_done),
  .flag_wcol   (flag_wcol),
  .flag_mfault (flag_mfault)
);

// File: tb/spi_mf_master_test.sv
`timescale 1ns/1ps
module spi_mf_master_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_wr, cfg_en, cfg_mstr, cfg_cpol, cfg_cpha;
  logic [1:0] cfg_rate;
  logic       dat_wr, dat_rd, sts_rd, ss_dir, ss_n, miso;
  logic [7:0] dat_wdata;
  logic [7:0] rx_data;
  logic       busy, flag_done, flag_wcol, flag_mfault, en_o, mstr_o, sck, mosi;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  spi_mf_master uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_mstr(cfg_mstr),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_rate(cfg_rate), .dat_wr(dat_wr),
    .dat_wdata(dat_wdata), .dat_rd(dat_rd), .sts_rd(sts_rd), .ss_dir(ss_dir),
    .ss_n(ss_n), .miso(miso), .rx_data(rx_data), .busy(busy), .flag_done(flag_done),
    .flag_wcol(flag_wcol), .flag_mfault(flag_mfault), .en_o(en_o), .mstr_o(mstr_o),
    .sck(sck), .mosi(mosi)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfgw(input logic e, input logic m, input logic p, input logic h,
                      input logic [1:0] r);
    cfg_en = e; cfg_mstr = m; cfg_cpol = p; cfg_cpha = h; cfg_rate = r;
    cfg_wr = 1'b1; step(1); cfg_wr = 1'b0;
  endtask

  task automatic pulse_sts; sts_rd = 1'b1; step(1); sts_rd = 1'b0; endtask
  task automatic pulse_rd;  dat_rd = 1'b1; step(1); dat_rd = 1'b0; endtask

  // One full exchange with a bench-side slave model.
  task automatic xfer(input logic [7:0] tx, input logic [7:0] sb, input logic pol,
                      input logic pha, input logic [1:0] rt, input bit inject);
    int   half, cyc, edges, bad_t, guard, k, idx;
    logic [7:0] got;
    logic last_sck, prev_mosi;
    bit   injected;
    half = (rt == 2'd0) ? 1 : (rt == 2'd1) ? 2 : (rt == 2'd2) ? 8 : 16;
    cfgw(1'b1, 1'b1, pol, pha, rt);
    check(sck == pol, "R2 idle level", sck, pol);
    miso = sb[7];
    dat_wdata = tx; dat_wr = 1'b1; step(1); dat_wr = 1'b0;
    cyc = -1; edges = 0; bad_t = 0; guard = 0; got = '0; injected = 0;
    last_sck = sck; prev_mosi = mosi;
    forever begin
      cyc++; guard++;
      if (sck != last_sck) begin
        k = edges;
        if (cyc != half) bad_t++;
        if (pha ? k[0] : !k[0]) begin
          idx = 7 - k / 2;
          got[idx] = prev_mosi;
        end
        if (pha ? (!k[0] && k >= 2) : (k[0] && k < 15)) begin
          idx = pha ? 7 - k / 2 : 7 - (k + 1) / 2;
          miso = sb[idx];
        end
        edges++; cyc = 0; last_sck = sck;
      end
      if (!busy || guard > 2000) break;
      if (inject && edges == 5 && !injected) begin
        dat_wdata = ~tx; dat_wr = 1'b1; injected = 1;
      end else dat_wr = 1'b0;
      prev_mosi = mosi;
      step(1);
    end
    dat_wr = 1'b0;
    check(edges == 16, "R1 edge count", edges, 16);
    check(got == tx, "R1/R3 mosi byte", got, tx);
    check(rx_data == sb, "R1 rx byte", rx_data, sb);
    check(bad_t == 0, "R4 half period", bad_t, 0);
    check(sck == pol, "R2 end level", sck, pol);
    check(flag_done == 1'b1, "R5 done set", flag_done, 1);
    check(flag_wcol == inject, "R6 wcol", flag_wcol, inject);
  endtask

  initial begin
    rst_n = 1'b0; cfg_wr = 0; cfg_en = 0; cfg_mstr = 0; cfg_cpol = 0; cfg_cpha = 0;
    cfg_rate = 0; dat_wr = 0; dat_rd = 0; sts_rd = 0; ss_dir = 0; ss_n = 1'b1;
    miso = 0; dat_wdata = 0;
    step(3); rst_n = 1'b1; step(2);

    check({sck, mosi, busy, flag_done, flag_wcol, flag_mfault, en_o, mstr_o} == 8'h00,
          "R10 reset outputs",
          {sck, mosi, busy, flag_done, flag_wcol, flag_mfault, en_o, mstr_o}, 0);
    check(rx_data == 8'h00, "R10 reset rx", rx_data, 0);

    // R9: transfers gated by enable and master
    cfgw(1'b0, 1'b1, 1'b1, 1'b0, 2'd0);
    dat_wdata = 8'h5A; dat_wr = 1'b1; step(1); dat_wr = 1'b0;
    for (int i = 0; i < 20; i++) begin
      check(busy == 1'b0 && sck == 1'b1, "R9 disabled ignore", {busy, sck}, 1);
      step(1);
    end
    cfgw(1'b1, 1'b0, 1'b0, 1'b0, 2'd0);
    dat_wr = 1'b1; step(1); dat_wr = 1'b0; step(4);
    check(busy == 1'b0 && sck == 1'b0, "R9 slave ignore", {busy, sck}, 0);

    // R1..R4: sweep of mode x rate x pattern
    for (int m = 0; m < 4; m++)
      for (int r = 0; r < 4; r++)
        for (int p = 0; p < 3; p++) begin
          logic [7:0] tx, sb;
          tx = 8'(8'hA5 + 37 * p + 13 * m + 71 * r);
          sb = 8'(~tx ^ (8'h3C + 29 * p + 5 * r));
          xfer(tx, sb, m[1], m[0], r[1:0], 1'b0);
          pulse_sts; pulse_rd;
          check(flag_done == 1'b0, "R5 done cleared", flag_done, 0);
        end

    // R5: data access without status read keeps the flag
    xfer(8'h81, 8'h7E, 1'b0, 1'b1, 2'd0, 1'b0);
    pulse_rd;
    check(flag_done == 1'b1, "R5 no clear w/o status", flag_done, 1);
    pulse_sts; pulse_rd;
    check(flag_done == 1'b0, "R5 clear sequence", flag_done, 0);

    // R6: collision leaves byte intact
    xfer(8'hC3, 8'h19, 1'b1, 1'b0, 2'd1, 1'b1);
    pulse_sts; pulse_rd;
    check(flag_wcol == 1'b0 && flag_done == 1'b0, "R6 wcol cleared",
          {flag_wcol, flag_done}, 0);

    // R7: idle fault
    cfgw(1'b1, 1'b1, 1'b1, 1'b0, 2'd0);
    ss_n = 1'b0; step(4);
    check(flag_mfault == 1'b1, "R7 fault flag", flag_mfault, 1);
    check(en_o == 1'b0 && mstr_o == 1'b0, "R7 bits dropped", {en_o, mstr_o}, 0);
    check(sck == 1'b1, "R7 sck idle", sck, 1);
    ss_n = 1'b1; step(3);
    dat_wr = 1'b1; step(1); dat_wr = 1'b0; step(2);
    check(busy == 1'b0, "R7 no start after fault", busy, 0);
    pulse_sts; cfgw(1'b0, 1'b0, 1'b0, 1'b0, 2'd0);
    check(flag_mfault == 1'b0, "R7 fault cleared", flag_mfault, 0);

    // R7: abort mid-transfer
    cfgw(1'b1, 1'b1, 1'b1, 1'b1, 2'd2);
    dat_wdata = 8'h66; dat_wr = 1'b1; step(1); dat_wr = 1'b0;
    step(30);
    check(busy == 1'b1, "R7 transfer running", busy, 1);
    ss_n = 1'b0; step(5);
    check(busy == 1'b0 && flag_mfault == 1'b1, "R7 abort", {busy, flag_mfault}, 3);
    check(flag_done == 1'b0, "R7 no done on abort", flag_done, 0);
    for (int i = 0; i < 40; i++) begin
      check(sck == 1'b1, "R7 sck parked", sck, 1);
      step(1);
    end
    ss_n = 1'b1; step(3);
    pulse_sts; cfgw(1'b0, 1'b0, 1'b1, 1'b1, 2'd2);
    check(flag_mfault == 1'b0, "R7 fault cleared again", flag_mfault, 0);

    // R8: masked select pin
    ss_dir = 1'b1; ss_n = 1'b0;
    xfer(8'h3E, 8'hD2, 1'b0, 1'b0, 2'd3, 1'b0);
    check(flag_mfault == 1'b0 && en_o == 1'b1, "R8 masked no fault",
          {flag_mfault, en_o}, 1);
    ss_n = 1'b1; ss_dir = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

endmodule